// File: doc/BRIEF.md
# Partitioned Rename Free List

This block holds the pool of free physical rename registers for a register renaming stage. It does not keep one shared queue. It keeps four circular queues, and each queue owns one fixed quarter of the physical register space. The top two bits of a logical register number decide which queue serves that register. Because of this, the physical bank a destination will land in is known before the allocation takes place. Power control for the register file banks can then act ahead of the access.

Each cycle, two source fields and one destination field arrive. The block reports the bank selected for each of the three fields. The destination field may also request an allocation, which pops the head of its queue. In the same cycle, one older physical register may be handed back on a release port. The release is routed by that physical register's own top bits.

All results are registered and appear one cycle after the request. Per-bank empty flags and occupancy counts are also provided.

Top module: `rfl_top`

## Requirements
- R1: After reset, every bank count reads 64, every bank empty flag reads 0, and both `alloc_valid` and `alloc_stall` read 0.
- R2: One cycle after a request, `src_a_bank`, `src_b_bank` and `dst_bank` each equal bits [5:4] of the matching logical register field.
- R3: A granted physical number has its bits [7:6] equal to the destination bank, so bank k only hands out numbers 64k to 64k+63.
- R4: After reset, consecutive grants from bank k return 64k, 64k+1, 64k+2 and so on in ascending order.
- R5: A granted allocation lowers that bank's count by one. An accepted release raises the count of its target bank by one.
- R6: An allocation request to a bank whose count is 0 gives `alloc_stall`=1 and `alloc_valid`=0. It leaves the count and the read position unchanged.
- R7: A released register enters the bank named by its own bits [7:6], whatever logical register held it.
- R8: When a granted allocation and an accepted release hit the same bank in one cycle, both take effect and the bank count stays the same.
- R9: Once a bank's initial contents are used up, registers released to that bank are granted again in the order they were released.
- R10: A release aimed at a bank whose count is 64 is ignored, and the count stays at 64.
- R11: `alloc_valid` and `alloc_stall` are never 1 together, and both are 0 in the cycle after a cycle with no destination request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_lreg | input | 6 | First source logical register |
| src_b_lreg | input | 6 | Second source logical register |
| dst_valid | input | 1 | Destination allocation request |
| dst_lreg | input | 6 | Destination logical register |
| rel_valid | input | 1 | Release request |
| rel_preg | input | 8 | Physical register being freed |
| src_a_bank | output | 2 | Bank selected for first source |
| src_b_bank | output | 2 | Bank selected for second source |
| dst_bank | output | 2 | Bank selected for destination |
| alloc_valid | output | 1 | Allocation granted |
| alloc_stall | output | 1 | Allocation refused, bank empty |
| alloc_preg | output | 8 | Granted physical register |
| bank_empty | output | 4 | Per-bank empty flag, bit k for bank k |
| bank_count | output | 28 | Per-bank count, bits [7k+6:7k] for bank k |

## Verification
Allocation and release can both act on one bank in the same cycle. The bench provokes this by taking one register from bank 2 and then, in a single cycle, requesting another bank-2 destination while returning the first register. It judges the result by the granted number (the next ascending value) and by the count, which must not move. A related collision is a release aimed at a full bank in the reset state. Another is a request to a drained bank, which must stall and then hand out released registers in their release order.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  localparam int LREG_W_DEF = 6;
  localparam int PREG_W_DEF = 8;
  localparam int BANKS_DEF  = 4;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_GRANT = 2'd1,
    OUT_STALL = 2'd2
  } alloc_out_e;
endpackage

// File: rtl/rfl_bank_sel.sv
module rfl_bank_sel #(
  parameter int LREG_W = 6,
  parameter int BANK_W = 2
) (
  input  logic [LREG_W-1:0] lreg,
  output logic [BANK_W-1:0] bank
);
  // group of logical registers is named by its upper bits
  assign bank = lreg[LREG_W-1 -: BANK_W];
endmodule

// File: rtl/rfl_bank_fifo.sv
module rfl_bank_fifo #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic             rel_req,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             grant,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W:0]   count,
  output logic             empty
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0] ram [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic             lapped_q;
  logic [CNT_W-1:0] count_q;
  logic             empty_q;
  logic             pop, push;

  assign pop   = alloc_req && (count_q != '0);
  assign push  = rel_req && (count_q != CNT_W'(DEPTH));
  assign grant = pop;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) ram[tail_q] <= rel_idx;
  end

  // slots the tail has not yet written still hold their reset value = own index
  assign head_idx = (lapped_q || (head_q < tail_q)) ? ram[head_q] : head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q   <= '0;
      tail_q   <= '0;
      lapped_q <= 1'b0;
      count_q  <= CNT_W'(DEPTH);
      empty_q  <= 1'b0;
    end else begin
      if (pop) head_q <= head_q + 1'b1;
      if (push) begin
        tail_q <= tail_q + 1'b1;
        if (tail_q == IDX_W'(DEPTH - 1)) lapped_q <= 1'b1;
      end
      if (pop && !push) begin
        count_q <= count_q - 1'b1;
        empty_q <= (count_q == CNT_W'(1));
      end else if (push && !pop) begin
        count_q <= count_q + 1'b1;
        empty_q <= 1'b0;
      end
    end
  end

  assign count = count_q;
  assign empty = empty_q;

  p_pop_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (count_q == $past(count_q) - CNT_W'(1)));
  p_push_inc_r5: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (count_q == $past(count_q) + CNT_W'(1)));
  p_both_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (pop && push) |=> $stable(count_q));
  p_empty_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && count_q == '0) |=> $stable(head_q));
  p_full_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (rel_req && !alloc_req && count_q == CNT_W'(DEPTH)) |=> (count_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/rfl_top.sv
module rfl_top
  import rfl_pkg::*;
#(
  parameter int LREG_W = LREG_W_DEF,
  parameter int PREG_W = PREG_W_DEF,
  parameter int BANKS  = BANKS_DEF,
  localparam int BANK_W = $clog2(BANKS),
  localparam int IDX_W  = PREG_W - BANK_W,
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LREG_W-1:0]       src_a_lreg,
  input  logic [LREG_W-1:0]       src_b_lreg,
  input  logic                    dst_valid,
  input  logic [LREG_W-1:0]       dst_lreg,
  input  logic                    rel_valid,
  input  logic [PREG_W-1:0]       rel_preg,
  output logic [BANK_W-1:0]       src_a_bank,
  output logic [BANK_W-1:0]       src_b_bank,
  output logic [BANK_W-1:0]       dst_bank,
  output logic                    alloc_valid,
  output logic                    alloc_stall,
  output logic [PREG_W-1:0]       alloc_preg,
  output logic [BANKS-1:0]        bank_empty,
  output logic [BANKS*CNT_W-1:0]  bank_count
);
  localparam int NFIELD = 3;

  logic [LREG_W-1:0] field [NFIELD];
  logic [BANK_W-1:0] fsel  [NFIELD];
  assign field[0] = src_a_lreg;
  assign field[1] = src_b_lreg;
  assign field[2] = dst_lreg;

  for (genvar f = 0; f < NFIELD; f++) begin : g_sel
    rfl_bank_sel #(.LREG_W(LREG_W), .BANK_W(BANK_W)) u_sel (
      .lreg (field[f]),
      .bank (fsel[f])
    );
  end

  logic [BANK_W-1:0] rel_bank;
  logic [IDX_W-1:0]  rel_idx;
  assign rel_bank = rel_preg[PREG_W-1 -: BANK_W];
  assign rel_idx  = rel_preg[IDX_W-1:0];

  logic [BANKS-1:0] grant;
  logic [IDX_W-1:0] head_idx [BANKS];

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    rfl_bank_fifo #(.IDX_W(IDX_W)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .alloc_req (dst_valid && (fsel[2] == BANK_W'(k))),
      .rel_req   (rel_valid && (rel_bank == BANK_W'(k))),
      .rel_idx   (rel_idx),
      .grant     (grant[k]),
      .head_idx  (head_idx[k]),
      .count     (cnt),
      .empty     (bank_empty[k])
    );
    assign bank_count[k*CNT_W +: CNT_W] = cnt;
  end

  alloc_out_e outcome;
  always_comb begin
    if (!dst_valid)          outcome = OUT_IDLE;
    else if (grant[fsel[2]]) outcome = OUT_GRANT;
    else                     outcome = OUT_STALL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_a_bank  <= '0;
      src_b_bank  <= '0;
      dst_bank    <= '0;
      alloc_valid <= 1'b0;
      alloc_stall <= 1'b0;
      alloc_preg  <= '0;
    end else begin
      src_a_bank  <= fsel[0];
      src_b_bank  <= fsel[1];
      dst_bank    <= fsel[2];
      alloc_valid <= (outcome == OUT_GRANT);
      alloc_stall <= (outcome == OUT_STALL);
      if (outcome == OUT_GRANT) alloc_preg <= {fsel[2], head_idx[fsel[2]]};
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(alloc_valid && alloc_stall));
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !dst_valid |=> (!alloc_valid && !alloc_stall));
  p_range_r3: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |-> (alloc_preg[PREG_W-1 -: BANK_W] == dst_bank));
  p_dst_sel_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dst_bank == $past(dst_lreg[LREG_W-1 -: BANK_W])));
endmodule

// File: tb/rfl_top_bench.sv
`timescale 1ns/1ps
module rfl_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] sa = '0, sb = '0, dl = '0;
  logic dv = 1'b0, rv = 1'b0;
  logic [7:0] rp = '0;
  logic [1:0] a_bk, b_bk, d_bk;
  logic av, ast;
  logic [7:0] apreg;
  logic [3:0] bempty;
  logic [27:0] bcount;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rfl_top u_rfl_top (
    .clk(clk), .rst(rst), .src_a_lreg(sa), .src_b_lreg(sb),
    .dst_valid(dv), .dst_lreg(dl), .rel_valid(rv), .rel_preg(rp),
    .src_a_bank(a_bk), .src_b_bank(b_bk), .dst_bank(d_bk),
    .alloc_valid(av), .alloc_stall(ast), .alloc_preg(apreg),
    .bank_empty(bempty), .bank_count(bcount)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int cnt(input int k);
    return int'(bcount[k*7 +: 7]);
  endfunction

  task automatic idle();
    dv = 1'b0; rv = 1'b0;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) begin
      chk("R1 count", cnt(k), 64);
      chk("R1 empty", int'(bempty[k]), 0);
    end
    chk("R1 valid", int'(av), 0);
    chk("R1 stall", int'(ast), 0);
  endtask

  task automatic t_select();
    sa = 6'h25; sb = 6'h3F; dl = 6'h0A; dv = 1'b0;
    tick();
    chk("R2 src_a", int'(a_bk), 2);
    chk("R2 src_b", int'(b_bk), 3);
    chk("R2 dst", int'(d_bk), 0);
    chk("R11 idle valid", int'(av), 0);
    chk("R11 idle stall", int'(ast), 0);
    sa = 6'h10; sb = 6'h0F; dl = 6'h31;
    tick();
    chk("R2 src_a", int'(a_bk), 1);
    chk("R2 src_b", int'(b_bk), 0);
    chk("R2 dst", int'(d_bk), 3);
  endtask

  task automatic t_ascend();
    for (int i = 0; i < 3; i++) begin
      dv = 1'b1; dl = 6'h10 + 6'(i);
      tick();
      chk("R4 ascending", int'(apreg), 64 + i);
      chk("R3 valid", int'(av), 1);
      chk("R3 range", int'(apreg[7:6]), 1);
    end
    idle();
    chk("R5 dec", cnt(1), 61);
  endtask

  task automatic t_release();
    rv = 1'b1; rp = 8'd200;
    tick();
    chk("R10 full ignored", cnt(3), 64);
    rp = 8'd65;
    tick();
    idle();
    chk("R7 own bank", cnt(1), 62);
    chk("R7 other bank", cnt(0), 64);
  endtask

  task automatic t_drain();
    for (int i = 0; i < 64; i++) begin
      dv = 1'b1; dl = 6'h03;
      tick();
      chk("R4 bank0 order", int'(apreg), i);
    end
    chk("R6 empty flag", int'(bempty[0]), 1);
    tick();
    chk("R6 stall", int'(ast), 1);
    chk("R6 no grant", int'(av), 0);
    chk("R6 count", cnt(0), 0);
    dv = 1'b0; rv = 1'b1; rp = 8'd7;
    tick();
    rp = 8'd3;
    tick();
    rv = 1'b0;
    chk("R5 inc", cnt(0), 2);
    dv = 1'b1; dl = 6'h0C;
    tick();
    chk("R9 first out", int'(apreg), 7);
    tick();
    chk("R9 second out", int'(apreg), 3);
    idle();
    tick();
  endtask

  task automatic t_same();
    dv = 1'b1; dl = 6'h21;
    tick();
    chk("R4 bank2 first", int'(apreg), 128);
    chk("R5 bank2", cnt(2), 63);
    rv = 1'b1; rp = 8'd128; dl = 6'h2E;
    tick();
    idle();
    chk("R8 grant", int'(apreg), 129);
    chk("R8 valid", int'(av), 1);
    chk("R8 count kept", cnt(2), 63);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick();
    tick();
    rst = 1'b0;
    t_reset();
    t_select();
    t_ascend();
    t_release();
    t_drain();
    t_same();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule